// File: doc/BRIEF.md
# Receive FIFO Error-Frame Filter

This block sits on the write side of a receive frame FIFO. It writes each byte of an arriving frame into the FIFO storage and, when the frame's end beat arrives, decides whether to keep or discard the frame. A kept frame is committed by advancing the write pointer that the read side can see, and its status word is handed on alongside it. A discarded frame is rewound: the committed pointer stays where it was, so the frame's bytes are overwritten by the next frame.

The keep/drop decision depends on the error flags in the status word, a forward-errors control input, and whether the reader has already started taking the frame's bytes in threshold mode. A frame the reader has already started on is always kept. Short (runt) frames are discarded even when error forwarding is on. If the FIFO fills partway through a frame, the bytes that do not fit are dropped and the frame's overflow flag is raised.

Top module: `rx_err_filter`

## Requirements
- R1: A frame is the span of beats from a start beat to an end beat. The status word has these bits: bit0 runt, bit1 CRC, bit2 collision, bit3 giant, bit4 watchdog, bit5 overflow. When a frame is kept, `commit_o` pulses in the cycle after its end beat. In that same cycle `wr_ptr_o` has advanced by the number of bytes written, and `stat_o` carries the frame's final status.
- R2: When `fwd_err_i` is 0 and the reader has not started, a frame with any of status bits 1 to 5 set is dropped. `rewind_o` pulses in the cycle after the end beat, and `wr_ptr_o` is unchanged.
- R3: A frame is a runt when status bit0 is set or when it has fewer than MIN_LEN (64) beats. A frame of exactly 64 beats is not a runt. A runt is dropped whatever the value of `fwd_err_i`, unless the reader has already started on it. A short frame that is kept reports bit0 set in `stat_o`.
- R4: When `fwd_err_i` is 1, a frame that is not a runt is kept whatever its other error bits, and those bits appear in `stat_o`.
- R5: When `rd_started_i` is 1 on the end beat, the frame is kept whatever its status and whatever the value of `fwd_err_i`.
- R6: Once the occupancy `wr_ptr - rd_ptr_i` reaches DEPTH (2048), the remaining bytes of the frame are not written (`mem_we_o` is 0), and the frame's status bit5 is set.
- R7: Each accepted byte is written through `mem_we_o`/`mem_addr_o`/`mem_data_o` in the same cycle it arrives. The frame's first byte goes to address `wr_ptr_o` modulo DEPTH, and the following bytes go to consecutive addresses.
- R8: Valid beats outside a frame are ignored (no write, no pointer change). A start beat inside an unfinished frame abandons that frame, and the abandoned frame never advances `wr_ptr_o`.
- R9: After reset, `wr_ptr_o` is 0 and `commit_o` and `rewind_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_err_i | input | 1 | Keep error frames other than runts |
| rx_valid_i | input | 1 | Byte beat valid |
| rx_sof_i | input | 1 | Beat is a frame's first byte |
| rx_eof_i | input | 1 | Beat is a frame's last byte |
| rx_data_i | input | 8 | Byte |
| rx_stat_i | input | 6 | Status flags, sampled on the end beat |
| rd_started_i | input | 1 | Reader already took this frame's first byte |
| rd_ptr_i | input | AW+1 | Read pointer, with a wrap bit |
| mem_we_o | output | 1 | FIFO storage write enable |
| mem_addr_o | output | AW | FIFO storage write address |
| mem_data_o | output | 8 | FIFO storage write data |
| wr_ptr_o | output | AW+1 | Committed write pointer, visible to the reader |
| commit_o | output | 1 | Frame kept; status valid |
| rewind_o | output | 1 | Frame dropped |
| stat_o | output | 6 | Final status of the kept frame |

## Verification
The assertions assume the following about the inputs:
- The read pointer never runs ahead of the committed write pointer, so the committed occupancy stays within DEPTH.
- `rx_stat_i` and `rd_started_i` are meaningful only on the end beat.

The stimulus keeps to these assumptions. It holds `rd_ptr_i` at zero while frames are written. It moves `rd_ptr_i` only to the committed pointer, which models a reader that has drained everything. It always closes a frame with an end beat, except in the one case that deliberately abandons a frame.

// File: rtl/rx_err_filter.sv
module rx_err_filter #(
  parameter int DEPTH   = 2048,
  parameter int MIN_LEN = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(MIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_err_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic [5:0]    rx_stat_i,
  input  logic          rd_started_i,
  input  logic [AW:0]   rd_ptr_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic [AW:0]   wr_ptr_o,
  output logic          commit_o,
  output logic          rewind_o,
  output logic [5:0]    stat_o
);

  logic          in_frame, ovf_hit;
  logic [AW:0]   wp;
  logic [LW-1:0] len;

  wire          accept  = rx_valid_i & (rx_sof_i | in_frame);
  wire [AW:0]   cur_wp  = rx_sof_i ? wr_ptr_o : wp;
  wire [LW-1:0] cur_len = rx_sof_i ? '0 : len;
  wire          cur_ovf = ~rx_sof_i & ovf_hit;
  wire          full    = (cur_wp - rd_ptr_i) == (AW+1)'(DEPTH);

  assign mem_we_o   = accept & ~full & ~cur_ovf;
  assign mem_addr_o = cur_wp[AW-1:0];
  assign mem_data_o = rx_data_i;

  wire [LW-1:0] nxt_len = (cur_len == LW'(MIN_LEN)) ? cur_len : cur_len + 1'b1;
  wire [AW:0]   nxt_wp  = cur_wp + {{AW{1'b0}}, mem_we_o};
  wire          short   = nxt_len < LW'(MIN_LEN);
  wire [5:0]    flags   = rx_stat_i | {cur_ovf | full, 4'b0000, short};
  wire          drop    = ~rd_started_i & (flags[0] | (~fwd_err_i & (|flags[5:1])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      ovf_hit  <= 1'b0;
      wp       <= '0;
      len      <= '0;
      wr_ptr_o <= '0;
      commit_o <= 1'b0;
      rewind_o <= 1'b0;
      stat_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      rewind_o <= 1'b0;
      if (accept) begin
        if (rx_eof_i) begin
          in_frame <= 1'b0;
          if (drop) begin
            rewind_o <= 1'b1;
            wp       <= wr_ptr_o;
          end else begin
            commit_o <= 1'b1;
            wr_ptr_o <= nxt_wp;
            wp       <= nxt_wp;
            stat_o   <= flags;
          end
        end else begin
          in_frame <= 1'b1;
          wp       <= nxt_wp;
          len      <= nxt_len;
          ovf_hit  <= cur_ovf | full;
        end
      end
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && rewind_o));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_o - rd_ptr_i) <= (AW+1)'(DEPTH));

  p_rewind_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_o |-> wr_ptr_o == $past(wr_ptr_o));

  p_runt_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_eof_i && rx_stat_i[0] && !rd_started_i) |=> rewind_o);

  p_started_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_eof_i && rd_started_i) |=> commit_o);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !rx_sof_i) |-> !mem_we_o);

endmodule

// File: tb/tb_rx_err_filter.sv
module tb_rx_err_filter;
  localparam int AW = 11;

  logic clk = 0, rst_n = 0;
  logic fwd = 0, vld = 0, sof = 0, eof = 0, rds = 0;
  logic [7:0] dat = 0;
  logic [5:0] st = 0;
  logic [AW:0] rdp = 0;
  logic mem_we, commit, rewind;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [AW:0] wr_ptr;
  logic [5:0] stat;

  always #4 clk = ~clk;

  rx_err_filter dut (
    .clk(clk), .rst_n(rst_n), .fwd_err_i(fwd), .rx_valid_i(vld), .rx_sof_i(sof),
    .rx_eof_i(eof), .rx_data_i(dat), .rx_stat_i(st), .rd_started_i(rds),
    .rd_ptr_i(rdp), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .wr_ptr_o(wr_ptr), .commit_o(commit), .rewind_o(rewind), .stat_o(stat));

  int total = 0, passed = 0;
  logic [AW:0] exp_ptr = 0;
  logic last_we;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  // len[22:15] fwd[14] rds[13] stat[12:7] keep[6] expstat[5:0]
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {8'd64,  1'b0, 1'b0, 6'h00, 1'b1, 6'h00},
    {8'd80,  1'b0, 1'b0, 6'h02, 1'b0, 6'h00},
    {8'd70,  1'b1, 1'b0, 6'h02, 1'b1, 6'h02},
    {8'd64,  1'b1, 1'b0, 6'h01, 1'b0, 6'h00},
    {8'd10,  1'b1, 1'b0, 6'h00, 1'b0, 6'h00},
    {8'd63,  1'b1, 1'b0, 6'h00, 1'b0, 6'h00},
    {8'd10,  1'b0, 1'b1, 6'h00, 1'b1, 6'h01},
    {8'd64,  1'b0, 1'b1, 6'h10, 1'b1, 6'h10},
    {8'd64,  1'b0, 1'b0, 6'h04, 1'b0, 6'h00},
    {8'd90,  1'b0, 1'b0, 6'h08, 1'b0, 6'h00},
    {8'd66,  1'b0, 1'b0, 6'h10, 1'b0, 6'h00},
    {8'd64,  1'b0, 1'b0, 6'h20, 1'b0, 6'h00},
    {8'd100, 1'b1, 1'b0, 6'h3e, 1'b1, 6'h3e},
    {8'd65,  1'b1, 1'b1, 6'h01, 1'b1, 6'h01}
  };

  task automatic send(input int len, input bit f, input bit r, input logic [5:0] s,
                      input bit close);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      vld = 1; sof = (i == 0); eof = close && (i == len - 1);
      dat = 8'(i + 3); st = eof ? s : 6'h00; fwd = f; rds = r;
      #1;
      if (i == 0) chk(mem_we && mem_addr == exp_ptr[AW-1:0], "R7 first addr",
                      int'(mem_addr), int'(exp_ptr[AW-1:0]));
      if (i == 1) chk(mem_addr == AW'(exp_ptr + 1) && mem_data == 8'd4, "R7 next addr",
                      int'(mem_addr), int'(AW'(exp_ptr + 1)));
      last_we = mem_we;
    end
    @(negedge clk);
    vld = 0; sof = 0; eof = 0; st = 0; rds = 0;
  endtask

  initial begin
    #1600000;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ptr == 0 && !commit && !rewind, "R9 reset", int'(wr_ptr), 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [22:0] e;
      e = VEC[v];
      send(int'(e[22:15]), e[14], e[13], e[12:7], 1);
      if (e[6]) begin
        exp_ptr = exp_ptr + (AW+1)'(e[22:15]);
        chk(commit && !rewind && wr_ptr == exp_ptr, "R1/R4/R5 keep", int'(wr_ptr), int'(exp_ptr));
        chk(stat == e[5:0], "R1/R3/R4 status", int'(stat), int'(e[5:0]));
      end else begin
        chk(rewind && !commit && wr_ptr == exp_ptr, "R2/R3 drop", int'(wr_ptr), int'(exp_ptr));
      end
    end

    // R8: beats outside a frame are ignored
    @(negedge clk);
    vld = 1; dat = 8'h55; #1;
    chk(!mem_we, "R8 idle beat", int'(mem_we), 0);
    @(negedge clk);
    vld = 0;
    @(negedge clk);
    chk(wr_ptr == exp_ptr && !commit, "R8 idle ptr", int'(wr_ptr), int'(exp_ptr));

    // R8: abandoned frame, then a fresh frame from the same pointer
    send(30, 1, 0, 6'h00, 0);
    send(70, 1, 0, 6'h00, 1);
    exp_ptr = exp_ptr + 70;
    chk(commit && wr_ptr == exp_ptr, "R8 abandon", int'(wr_ptr), int'(exp_ptr));

    // R3/R5: single-beat frame with the reader started
    send(1, 0, 1, 6'h00, 1);
    exp_ptr = exp_ptr + 1;
    chk(commit && wr_ptr == exp_ptr && stat == 6'h01, "R5 one-beat", int'(stat), 1);

    // R6: overflow with forwarding on, kept and full
    send(2100, 1, 0, 6'h00, 1);
    exp_ptr = 12'd2048;
    chk(!last_we, "R6 no write when full", int'(last_we), 0);
    chk(commit && wr_ptr == exp_ptr, "R6 ptr full", int'(wr_ptr), int'(exp_ptr));
    chk(stat == 6'h20, "R6 overflow flag", int'(stat), 32);

    // R6/R2: overflow with forwarding off is dropped
    rdp = 12'd2048;
    send(2100, 0, 0, 6'h00, 1);
    chk(rewind && wr_ptr == exp_ptr, "R6 overflow drop", int'(wr_ptr), int'(exp_ptr));

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule